// File: doc/BRIEF.md
# Manchester word decoder

This block turns a Manchester II line into framed words. It takes the line level either as a complementary bipolar pair or as a single unipolar bit, samples it at twelve times the bit rate, and first looks for a word sync. A word sync is an over-long pulse that lasts one and a half bit times at one level and then the same time at the other level. The level of the first half says whether the word is a command word or a data word. The mid-sync transition sets the phase of a recovered shift clock, which runs at one twelfth of the sampling clock. Each of the following sixteen data bits and the single parity bit is then sampled at fixed points inside its bit cell.

The decoded bits leave the block as an NRZ stream on `nrz_out`, framed by `take_data`, with `cmd_sync` giving the sync type for the word. After the word, `word_ok` pulses if every bit cell held a mid-cell transition and the parity was odd. This output stream has no ready input and cannot be stalled. A bit is on offer for exactly one shift clock period, and a receiver that misses it loses it. Back-pressure therefore has to be handled downstream, for example by buffering bits on the shift clock rising edge.

Top module: `manchester_rx`

## Requirements
- R1: The line level is 1 when `line_pos` is high and `line_neg` is low, and 0 when `line_pos` is low and `line_neg` is high. In unipolar use (`line_neg` high, `line_pos` low) the level follows `line_uni`. The level is registered once before any use.
- R2: `shift_clk` is a free-running clock with a period of 12 `clk_12x` cycles, high for 6 cycles and then low for 6. After an accepted sync it rises, restarting its period, exactly 18 cycles after the cycle in which the registered level showed the mid-sync transition.
- R3: A sync is accepted only while no word is in progress. It requires a first run of 16 to 20 samples at one level, followed by at least 16 samples at the opposite level. A first run of 15 or of 21 samples produces no word: `take_data` and `word_ok` stay low and the shift clock phase is unchanged.
- R4: `cmd_sync` is high together with `take_data` when the sync's first half was level 1 (command sync). It stays low for a word whose first half was level 0 (data sync).
- R5: Bit cell n starts 18 + 12n cycles after the mid-sync transition. Each cell is sampled 3 and 9 cycles into the cell, and the bit value is the first sample (1 = high then low). Bits appear on `nrz_out` in order of arrival, each held for 12 cycles. `nrz_out` is 0 whenever `take_data` is low.
- R6: `take_data` rises one cycle after the second sample of data bit 1, provided bits 0 and 1 were both clean. It then stays high for 192 cycles, during which `nrz_out` carries data bits 0 to 15.
- R7: A bit cell whose two samples are equal is a Manchester error. An error in bit 0 or bit 1 keeps `take_data` low for the whole word. An error in any of the 17 cells keeps `word_ok` low.
- R8: Parity is odd over the 16 data bits plus the parity bit. `word_ok` is high for 12 cycles starting in the cycle that `take_data` falls, and only for a clean word with correct parity.
- R9: If `drst` (registered like the line) is high in the cycle before a `shift_clk` rising edge, the word is abandoned from the next cycle: `take_data` and `word_ok` go low and the decoder waits for a new sync.
- R10: While `mrst` is high, `take_data`, `nrz_out`, `cmd_sync` and `word_ok` are 0 and `shift_clk` is 1. The first clock after release is phase 1 of the free-running period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_12x | input | 1 | Sampling clock at twelve times the bit rate |
| mrst | input | 1 | Asynchronous master reset, active high |
| drst | input | 1 | Decoder word reset, acts before a shift clock rising edge |
| line_pos | input | 1 | High while the line is in its positive state |
| line_neg | input | 1 | High while the line is in its negative state; held high for unipolar use |
| line_uni | input | 1 | Unipolar line level; held low when unused |
| shift_clk | output | 1 | Recovered bit clock, sampling clock divided by 12 |
| nrz_out | output | 1 | Decoded data bits in NRZ form |
| take_data | output | 1 | Frames the 16 data bits on `nrz_out` |
| cmd_sync | output | 1 | High during a word that followed a command sync |
| word_ok | output | 1 | One bit-period pulse for a clean word with odd parity |

## Verification
The assertions assume the line pair is always in one of the two legal configurations, either complementary bipolar or unipolar with `line_neg` high and `line_pos` low. They also assume that every sync starts with a transition out of the opposite level, and that words are separated by a gap long enough for the previous word to finish. The stimulus builds each word from exact 12-sample cells. It precedes each sync with 30 samples at the level opposite its first half and leaves 40 idle samples after the parity cell. Errors enter only as whole constant cells, wrong parity bits, or a sync half of out-of-window length. `drst` is held for one full bit cell, so it covers exactly one phase before a shift clock rising edge.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  // Default oversampling ratio, word size and sync length tolerance.
  parameter int unsigned DEF_OVS       = 12;
  parameter int unsigned DEF_DATA_BITS = 16;
  parameter int unsigned DEF_TOL       = 2;

  typedef struct packed {
    logic hit;  // a legal sync was just completed
    logic cmd;  // its first half was level 1
  } mrx_sync_t;
endpackage

// File: rtl/mrx_line_in.sv
module mrx_line_in (
  input  logic clk,
  input  logic rst,
  input  logic line_pos,
  input  logic line_neg,
  input  logic line_uni,
  input  logic drst,
  output logic lvl,
  output logic lvl_d,
  output logic drst_r
);
  // Bipolar: pos wins. Unipolar: neg held high lets uni through.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      lvl    <= 1'b0;
      lvl_d  <= 1'b0;
      drst_r <= 1'b0;
    end else begin
      lvl    <= line_pos | (line_neg & line_uni);
      lvl_d  <= lvl;
      drst_r <= drst;
    end
  end
endmodule

// File: rtl/mrx_sync_det.sv
module mrx_sync_det
  import mrx_pkg::*;
#(
  parameter int unsigned OVS = DEF_OVS,
  parameter int unsigned TOL = DEF_TOL
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  input  logic      lvl_d,
  output mrx_sync_t sync
);
  localparam int unsigned HALF = (OVS * 3) / 2;
  localparam int unsigned SMIN = HALF - TOL;
  localparam int unsigned SMAX = HALF + TOL;
  localparam int unsigned CW   = $clog2(SMAX + 2) + 1;
  localparam logic [CW-1:0] C_MIN  = CW'(SMIN);
  localparam logic [CW-1:0] C_MAX  = CW'(SMAX);
  localparam logic [CW-1:0] C_TRIG = CW'(SMIN - 1);

  logic [CW-1:0] cnt;   // samples in the current run
  logic [CW-1:0] flen;  // length of the run that preceded it
  logic          fpol;  // level of that preceding run
  logic          flip;

  assign flip = lvl ^ lvl_d;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt  <= '0;
      flen <= '0;
      fpol <= 1'b0;
    end else if (flip) begin
      flen <= cnt;
      fpol <= lvl_d;
      cnt  <= CW'(1);
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Second half reaches its minimum length after a first half in window.
  assign sync.hit = !flip && (cnt == C_TRIG) && (flen >= C_MIN) && (flen <= C_MAX);
  assign sync.cmd = fpol;

  a_r3_run_saturates: assert property (@(posedge clk) disable iff (rst)
    (cnt == '1 && !flip) |=> (cnt == '1));
endmodule

// File: rtl/mrx_phase_gen.sv
module mrx_phase_gen
  import mrx_pkg::*;
#(
  parameter int unsigned OVS = DEF_OVS,
  parameter int unsigned TOL = DEF_TOL
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   relock,
  output logic [$clog2(OVS)-1:0] ph,
  output logic                   sclk
);
  localparam int unsigned PW = $clog2(OVS);
  // Loaded one cycle after the hit so that phase 0 lands 1.5 bits after the mid-sync edge.
  localparam logic [PW-1:0] P_LOAD = PW'(OVS - TOL);
  localparam logic [PW-1:0] P_LAST = PW'(OVS - 1);
  localparam logic [PW-1:0] P_HALF = PW'(OVS / 2);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                ph <= '0;
    else if (relock)        ph <= P_LOAD;
    else if (ph == P_LAST)  ph <= '0;
    else                    ph <= ph + 1'b1;
  end

  assign sclk = (ph < P_HALF);

  a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
    ph <= P_LAST);
  a_r2_relock_low: assert property (@(posedge clk) disable iff (rst)
    relock |=> !sclk);
endmodule

// File: rtl/mrx_bit_engine.sv
module mrx_bit_engine
  import mrx_pkg::*;
#(
  parameter int unsigned OVS       = DEF_OVS,
  parameter int unsigned DATA_BITS = DEF_DATA_BITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lvl,
  input  logic                   drst_r,
  input  mrx_sync_t              sync,
  input  logic [$clog2(OVS)-1:0] ph,
  output logic                   relock,
  output logic                   nrz_out,
  output logic                   take_data,
  output logic                   cmd_sync,
  output logic                   word_ok
);
  localparam int unsigned PW   = $clog2(OVS);
  localparam int unsigned DONE = DATA_BITS + 2;
  localparam int unsigned BW   = $clog2(DONE + 1);
  localparam logic [PW-1:0] P_Q1   = PW'(OVS / 4);
  localparam logic [PW-1:0] P_Q3   = PW'((OVS * 3) / 4);
  localparam logic [PW-1:0] P_Q3N  = PW'((OVS * 3) / 4 + 1);
  localparam logic [PW-1:0] P_LAST = PW'(OVS - 1);
  localparam logic [BW-1:0] B_ONE  = BW'(1);
  localparam logic [BW-1:0] B_PAR  = BW'(DATA_BITS);
  localparam logic [BW-1:0] B_TEND = BW'(DATA_BITS + 1);
  localparam logic [BW-1:0] B_DONE = BW'(DONE);

  logic          busy, h1, prev, sdo_r, take_r, ok_r, ok_pend, err, par, cmd_r;
  logic [BW-1:0] bidx;
  logic          rst_edge, bad;

  assign rst_edge = drst_r && (ph == P_LAST);
  assign relock   = sync.hit && !busy && !rst_edge;
  assign bad      = (h1 == lvl);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      busy <= 1'b0; h1 <= 1'b0; prev <= 1'b0; sdo_r <= 1'b0;
      take_r <= 1'b0; ok_r <= 1'b0; ok_pend <= 1'b0;
      err <= 1'b0; par <= 1'b0; cmd_r <= 1'b0; bidx <= '0;
    end else if (rst_edge) begin
      busy <= 1'b0; take_r <= 1'b0; ok_r <= 1'b0; bidx <= '0;
    end else if (relock) begin
      busy <= 1'b1; bidx <= '0; err <= 1'b0; par <= 1'b0;
      take_r <= 1'b0; ok_r <= 1'b0; cmd_r <= sync.cmd;
    end else if (busy) begin
      if (ph == P_Q1) h1 <= lvl;
      if (ph == P_Q3) begin
        bidx <= bidx + 1'b1;
        if (bidx <= B_PAR) begin
          err   <= err | bad;
          par   <= par ^ h1;
          prev  <= h1;
          sdo_r <= prev;   // output runs one bit behind the line
        end
        if (bidx == B_ONE) take_r  <= !(err | bad);
        if (bidx == B_PAR) ok_pend <= !(err | bad) && (par ^ h1);
        if (bidx == B_TEND) begin
          take_r <= 1'b0;
          ok_r   <= ok_pend;
        end
        if (bidx == B_DONE) begin
          ok_r <= 1'b0;
          busy <= 1'b0;
        end
      end
    end
  end

  assign take_data = take_r;
  assign nrz_out   = sdo_r & take_r;
  assign cmd_sync  = cmd_r & take_r;
  assign word_ok   = ok_r;

  a_r6_take_rise_phase: assert property (@(posedge clk) disable iff (rst)
    $rose(take_r) |-> (ph == P_Q3N));
  a_r7_take_needs_clean: assert property (@(posedge clk) disable iff (rst)
    $rose(take_r) |-> !err);
  a_r8_ok_follows_take: assert property (@(posedge clk) disable iff (rst)
    $rose(ok_r) |-> $fell(take_r));
  a_r3_start_from_sync: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(sync.hit));
  a_r9_reset_idles: assert property (@(posedge clk) disable iff (rst)
    rst_edge |=> (!busy && !take_r && !ok_r));
endmodule

// File: rtl/manchester_rx.sv
module manchester_rx
  import mrx_pkg::*;
#(
  parameter int unsigned OVS       = DEF_OVS,
  parameter int unsigned DATA_BITS = DEF_DATA_BITS,
  parameter int unsigned TOL       = DEF_TOL
) (
  input  logic clk_12x,
  input  logic mrst,
  input  logic drst,
  input  logic line_pos,
  input  logic line_neg,
  input  logic line_uni,
  output logic shift_clk,
  output logic nrz_out,
  output logic take_data,
  output logic cmd_sync,
  output logic word_ok
);
  localparam int unsigned PW = $clog2(OVS);

  logic          lvl, lvl_d, drst_r, relock;
  logic [PW-1:0] ph;
  mrx_sync_t     sync;

  mrx_line_in u_line (
    .clk(clk_12x), .rst(mrst), .line_pos(line_pos), .line_neg(line_neg),
    .line_uni(line_uni), .drst(drst), .lvl(lvl), .lvl_d(lvl_d), .drst_r(drst_r)
  );

  mrx_sync_det #(.OVS(OVS), .TOL(TOL)) u_sync (
    .clk(clk_12x), .rst(mrst), .lvl(lvl), .lvl_d(lvl_d), .sync(sync)
  );

  mrx_phase_gen #(.OVS(OVS), .TOL(TOL)) u_phase (
    .clk(clk_12x), .rst(mrst), .relock(relock), .ph(ph), .sclk(shift_clk)
  );

  mrx_bit_engine #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_eng (
    .clk(clk_12x), .rst(mrst), .lvl(lvl), .drst_r(drst_r), .sync(sync), .ph(ph),
    .relock(relock), .nrz_out(nrz_out), .take_data(take_data),
    .cmd_sync(cmd_sync), .word_ok(word_ok)
  );

  a_r8_ok_excludes_take: assert property (@(posedge clk_12x) disable iff (mrst)
    !(take_data && word_ok));
  a_r4_cmd_held: assert property (@(posedge clk_12x) disable iff (mrst)
    (take_data && $past(take_data)) |-> $stable(cmd_sync));
endmodule

// File: tb/manchester_rx_tb.sv
module manchester_rx_tb;
  logic clk = 1'b0, mrst = 1'b1, drst = 1'b0;
  logic lp = 1'b0, ln = 1'b0, lu = 1'b0;
  logic shift_clk, nrz_out, take_data, cmd_sync, word_ok;

  always #5 clk = ~clk;

  manchester_rx u_dut (
    .clk_12x(clk), .mrst(mrst), .drst(drst), .line_pos(lp), .line_neg(ln),
    .line_uni(lu), .shift_clk(shift_clk), .nrz_out(nrz_out),
    .take_data(take_data), .cmd_sync(cmd_sync), .word_ok(word_ok)
  );

  int checks = 0, fails = 0, sidx = 0;
  bit uni_mode = 0, done = 0;
  // reference model state
  int base_old = -1, base_new = -1, sw = 0;
  bit have_w = 0, w_take_en = 0, w_ok = 0, w_cmd = 0;
  int wB = 0, wkill = 0;
  bit [16:0] w_bits;
  int seen_take = 0, seen_ok = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int modp(int x);
    return ((x % 12) + 12) % 12;
  endfunction

  task automatic check_cycle(int j);
    int ph, t1, t17, t18;
    bit es, et, en, ec, eo;
    ph = (j >= sw) ? modp(j - base_new) : modp(j - base_old);
    es = (ph < 6);
    et = 0; en = 0; ec = 0; eo = 0;
    if (have_w && j < wkill) begin
      t1  = wB + 21;
      t17 = wB + 12 * 17 + 9;
      t18 = t17 + 12;
      et = w_take_en && (j > t1) && (j <= t17);
      if (et) en = w_bits[(j - t1 - 1) / 12];
      ec = et && w_cmd;
      eo = w_ok && (j > t17) && (j <= t18);
    end
    chk("R2 shift_clk", shift_clk, es);
    chk("R6 take_data", take_data, et);
    chk("R5 nrz_out", nrz_out, en);
    chk("R4 cmd_sync", cmd_sync, ec);
    chk("R8 word_ok", word_ok, eo);
    if (take_data) seen_take++;
    if (word_ok) seen_ok++;
  endtask

  task automatic drive(bit level, bit rs);
    lp = uni_mode ? 1'b0 : level;
    ln = uni_mode ? 1'b1 : !level;
    lu = uni_mode ? level : 1'b0;
    drst = rs;
    sidx++;
  endtask

  task automatic step(bit level, bit rs);
    @(negedge clk);
    check_cycle(sidx - 1);
    drive(level, rs);
  endtask

  // errb / rstb: bit cell with constant level / with drst high, -1 for none
  task automatic send_word(bit c, int len1, bit [15:0] d, bit pflip,
                           int errb, int rstb, bit acc, string tag);
    bit [16:0] bits;
    int j0, exp_t;
    bits = {(~^d) ^ pflip, d};
    repeat (30) step(!c, 0);
    repeat (len1) step(c, 0);
    j0 = sidx;
    if (acc) begin
      base_old = base_new; base_new = j0 + 18; sw = j0 + 16;
      have_w = 1; wB = j0 + 18;
      wkill = (rstb >= 0) ? (wB + 12 * rstb + 12) : 32'h3fffffff;
      w_take_en = !(errb == 0 || errb == 1);
      w_ok = (errb < 0) && !pflip && (rstb < 0);
      w_cmd = c; w_bits = bits;
    end
    seen_take = 0; seen_ok = 0;
    repeat (18) step(!c, 0);
    for (int b = 0; b < 17; b++)
      for (int s = 0; s < 12; s++)
        step((errb == b) ? bits[b] : ((s < 6) ? bits[b] : !bits[b]), (b == rstb));
    repeat (40) step(!c, 0);
    if (!acc || errb == 0 || errb == 1) exp_t = 0;
    else if (rstb >= 2) exp_t = 12 * rstb - 10;
    else exp_t = 192;
    chk({tag, " take cycles"}, seen_take, exp_t);
    chk({tag, " word_ok cycles"}, seen_ok, (acc && w_ok) ? 12 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    @(negedge clk);
    chk("R10 reset shift_clk", shift_clk, 1);
    chk("R10 reset take_data", take_data, 0);
    chk("R10 reset nrz_out", nrz_out, 0);
    chk("R10 reset cmd_sync", cmd_sync, 0);
    chk("R10 reset word_ok", word_ok, 0);
    mrst = 1'b0;
    drive(0, 0);
    repeat (20) step(0, 0);
    send_word(1, 18, 16'hA5C3, 0, -1, -1, 1, "R4 R8 command word");
    send_word(0, 18, 16'h1234, 0, -1, -1, 1, "R4 data word");
    send_word(1, 16, 16'h0F0F, 0, -1, -1, 1, "R3 short sync 16");
    send_word(0, 20, 16'hF00D, 0, -1, -1, 1, "R3 long sync 20");
    send_word(1, 15, 16'h5555, 0, -1, -1, 0, "R3 reject sync 15");
    send_word(0, 21, 16'hAAAA, 0, -1, -1, 0, "R3 reject sync 21");
    send_word(1, 18, 16'h8001, 1, -1, -1, 1, "R8 bad parity");
    send_word(0, 18, 16'h3C3C, 0, 5, -1, 1, "R7 error bit 5");
    send_word(1, 18, 16'h7777, 0, 1, -1, 1, "R7 error bit 1");
    send_word(1, 18, 16'hBEEF, 0, -1, 8, 1, "R9 decoder reset");
    send_word(0, 18, 16'h6B2D, 0, -1, -1, 1, "R9 word after reset");
    uni_mode = 1;
    send_word(1, 18, 16'hFFFF, 0, -1, -1, 1, "R1 unipolar command");
    send_word(0, 18, 16'h0000, 0, -1, -1, 1, "R1 unipolar data");
    repeat (10) step(0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule